// File: doc/BRIEF.md
# Two-Wire Command Front End for a Dual Digital Potentiometer

This block is the serial slave side of a dual digital potentiometer. It watches the bus clock and data lines with the system clock, finds start and stop conditions, and takes in one byte per nine bus clocks. The first byte is the address. It holds a fixed 4-bit type code and four address pins. The second byte is the instruction: an opcode nibble, a pot selector and a register selector. The block then ends the command, accepts one write byte, returns one read byte, or enters a stepping mode that nudges a wiper once per bus clock.

Everything the register bank must do is presented as a one-cycle request. A request goes out only when the master closes the transaction with a stop, because a nonvolatile write may only begin there. Stepping is the exception: it issues one request per bus clock pulse. While the bank reports itself busy, the block does not acknowledge its address, so a host can poll until the store completes. For reads the block publishes the selected pot, register and wiper flag, and the bank answers on `rd_data`.

The state machine walks IDLE → ADDR → ADDR_ACK → INSTR → INSTR_ACK. From INSTR_ACK it goes to HOLD (a two-byte command), to WR_DATA → WR_ACK → HOLD (a write), to RD_DATA → RD_ACK → IDLE (a read), or to STEP. A start in any state goes to ADDR. A stop in any state goes to IDLE, and a stop seen in HOLD emits the request. An address mismatch, a busy bank or an undefined opcode sends ADDR or INSTR straight back to IDLE without an acknowledge.

Top module: `tw_pot_cmd_frontend`

## Requirements
- R1: After reset, `sda_oe` is 0 and `req_valid` is 0.
- R2: An address byte is acknowledged (SDA held low during the ninth SCL high) only when it equals type code 0101 in bits 7..4 and `dev_addr` in bits 3..0. On any mismatch there is no acknowledge, and later bytes are ignored until the next start.
- R3: While `bank_busy` is 1 when the address byte completes, the address is not acknowledged. With the same address and the bank idle, it is acknowledged.
- R4: The instruction byte carries the opcode in bits 7..4, the pot in bit 2 and the register in bits 1..0. A defined opcode is acknowledged.
- R5: An undefined opcode (any nibble other than 0001, 0010, 1000, 1001, 1010, 1011, 1100, 1101, 1110) is not acknowledged, and no request follows at the stop.
- R6: Two-byte commands 1101, 1110, 0001 and 1000 produce exactly one `req_valid` pulse after the stop. `req_op` carries the opcode nibble, with `req_pot` and `req_reg` taken from the instruction.
- R7: Write commands 1010 and 1100 acknowledge the data byte. The request that follows carries it on `req_data`.
- R8: No request is issued before the stop. A repeated start before the stop discards the pending command.
- R9: Read commands 1011 and 1001 drive `rd_data` most significant bit first on the eight clocks after the instruction acknowledge, then release SDA for the master's acknowledge. `sel_wiper` is 1 for 1001 and 0 for 1011.
- R10: After opcode 0010 is acknowledged, each SCL pulse issues one request with `req_op` 0010 and `req_up` equal to the SDA level during that pulse. The closing stop adds no step.
- R11: `sda_oe` only changes while SCL is low, apart from a release forced by a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_addr | input | 4 | Pin-strapped device address |
| bank_busy | input | 1 | Register bank nonvolatile write in progress |
| rd_data | input | 8 | Bank value for the current selection |
| sel_pot | output | 1 | Pot selected by the last instruction |
| sel_reg | output | 2 | Register selected by the last instruction |
| sel_wiper | output | 1 | 1 when the read targets the wiper |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Opcode nibble of the request |
| req_pot | output | 1 | Pot of the request |
| req_reg | output | 2 | Register of the request |
| req_data | output | 8 | Write data byte |
| req_up | output | 1 | Step direction, 1 toward the high end |

## Verification
The bus inputs pass through two synchronizer flops and one edge register. The acknowledge enable or the next read bit therefore appears about four system clocks after an SCL falling edge, and a request strobe appears about four clocks after a stop. The bench holds each SCL phase for eight clocks. It samples SDA twice within each high phase, well clear of the update, and it counts request strobes with a monitor at the falling clock edge. Each count is compared ten clocks after the stop or step that caused it.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;

    localparam logic [3:0] OP_GDR2W = 4'b0001;
    localparam logic [3:0] OP_STEP  = 4'b0010;
    localparam logic [3:0] OP_GW2DR = 4'b1000;
    localparam logic [3:0] OP_RDW   = 4'b1001;
    localparam logic [3:0] OP_WRW   = 4'b1010;
    localparam logic [3:0] OP_RDR   = 4'b1011;
    localparam logic [3:0] OP_WRR   = 4'b1100;
    localparam logic [3:0] OP_DR2W  = 4'b1101;
    localparam logic [3:0] OP_W2DR  = 4'b1110;

    typedef enum logic [2:0] {
        CLS_BAD,
        CLS_XFER,
        CLS_READ,
        CLS_WRITE,
        CLS_STEP
    } cmd_cls_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_HOLD,
        ST_STEP
    } fsm_state_e;
endpackage

// File: rtl/tw_line_monitor.sv
module tw_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_sync;
    logic [LAST:0] sda_sync;
    logic          scl_q;
    logic          sda_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_in;
                    sda_sync <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[LAST-1:0], scl_in};
                    sda_sync <= {sda_sync[LAST-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_sync[LAST];
            sda_q <= sda_sync[LAST];
        end
    end

    assign scl_lvl  = scl_sync[LAST];
    assign sda_lvl  = sda_sync[LAST];
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tw_instr_decode.sv
module tw_instr_decode
    import tw_pkg::*;
(
    input  logic [3:0] op_nib,
    output cmd_cls_e   cls
);
    always_comb begin
        case (op_nib)
            OP_DR2W, OP_W2DR, OP_GDR2W, OP_GW2DR: cls = CLS_XFER;
            OP_RDW, OP_RDR:                       cls = CLS_READ;
            OP_WRW, OP_WRR:                       cls = CLS_WRITE;
            OP_STEP:                              cls = CLS_STEP;
            default:                              cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/tw_cmd_fsm.sv
module tw_cmd_fsm
    import tw_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic [3:0]        dev_addr,
    input  logic              bank_busy,
    input  logic [BYTE_W-1:0] rd_data,
    input  cmd_cls_e          cls_in,
    output logic [3:0]        op_nib,
    output logic              sda_oe,
    output logic              sel_pot,
    output logic [1:0]        sel_reg,
    output logic              sel_wiper,
    output logic              req_valid,
    output logic [3:0]        req_op,
    output logic              req_pot,
    output logic [1:0]        req_reg,
    output logic [BYTE_W-1:0] req_data,
    output logic              req_up
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    fsm_state_e        state, state_d;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              full;
    logic              addr_ok;
    logic              rx_state;
    logic              counting;
    logic [3:0]        op_q;
    logic              pot_q;
    logic [1:0]        reg_q;
    cmd_cls_e          cls_q;
    logic [BYTE_W-1:0] data_q;
    logic              step_arm;
    logic              step_dir;

    assign full     = (bit_cnt == FULL_CNT);
    assign addr_ok  = (shreg == {TYPE_CODE, dev_addr});
    assign op_nib   = shreg[BYTE_W-1 -: 4];
    assign rx_state = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_WR_DATA);
    assign counting = rx_state || (state == ST_RD_DATA);

    // next-state logic
    always_comb begin
        state_d = state;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR:
                    if (scl_fall && full)
                        state_d = (addr_ok && !bank_busy) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:
                    if (scl_fall) state_d = ST_INSTR;
                ST_INSTR:
                    if (scl_fall && full)
                        state_d = (cls_in != CLS_BAD) ? ST_INSTR_ACK : ST_IDLE;
                ST_INSTR_ACK:
                    if (scl_fall) begin
                        unique case (cls_q)
                            CLS_READ:  state_d = ST_RD_DATA;
                            CLS_WRITE: state_d = ST_WR_DATA;
                            CLS_STEP:  state_d = ST_STEP;
                            CLS_XFER:  state_d = ST_HOLD;
                            CLS_BAD:   state_d = ST_IDLE;
                        endcase
                    end
                ST_WR_DATA:
                    if (scl_fall && full) state_d = ST_WR_ACK;
                ST_WR_ACK:
                    if (scl_fall) state_d = ST_HOLD;
                ST_RD_DATA:
                    if (scl_fall && full) state_d = ST_RD_ACK;
                ST_RD_ACK:
                    if (scl_fall) state_d = ST_IDLE;
                ST_HOLD: state_d = ST_HOLD;
                ST_STEP: state_d = ST_STEP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // byte datapath and latched command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            op_q     <= '0;
            pot_q    <= 1'b0;
            reg_q    <= '0;
            cls_q    <= CLS_BAD;
            data_q   <= '0;
            step_arm <= 1'b0;
            step_dir <= 1'b0;
        end else begin
            if (start_ev || (state_d != state))
                bit_cnt <= '0;
            else if (scl_rise && counting && !full)
                bit_cnt <= bit_cnt + 1'b1;

            if (scl_rise && rx_state && !full)
                shreg <= {shreg[BYTE_W-2:0], sda_lvl};
            else if ((state == ST_INSTR_ACK) && (state_d == ST_RD_DATA))
                shreg <= rd_data;
            else if (scl_fall && (state == ST_RD_DATA) && !full)
                shreg <= {shreg[BYTE_W-2:0], 1'b0};

            if ((state == ST_INSTR) && (state_d == ST_INSTR_ACK)) begin
                op_q  <= shreg[BYTE_W-1 -: 4];
                pot_q <= shreg[2];
                reg_q <= shreg[1:0];
                cls_q <= cls_in;
            end

            if ((state == ST_WR_DATA) && (state_d == ST_WR_ACK))
                data_q <= shreg;

            if (state != ST_STEP) begin
                step_arm <= 1'b0;
            end else if (scl_rise) begin
                step_arm <= 1'b1;
                step_dir <= sda_lvl;
            end else if (scl_fall) begin
                step_arm <= 1'b0;
            end
        end
    end

    // output register: bus drive and request strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            req_valid <= 1'b0;
            req_op    <= '0;
            req_pot   <= 1'b0;
            req_reg   <= '0;
            req_data  <= '0;
            req_up    <= 1'b0;
        end else begin
            if (start_ev || stop_ev) begin
                sda_oe <= 1'b0;
            end else if (scl_fall) begin
                unique case (state_d)
                    ST_ADDR_ACK, ST_INSTR_ACK, ST_WR_ACK: sda_oe <= 1'b1;
                    ST_RD_DATA:
                        sda_oe <= (state == ST_INSTR_ACK) ? ~rd_data[BYTE_W-1]
                                                          : ~shreg[BYTE_W-2];
                    default: sda_oe <= 1'b0;
                endcase
            end

            req_valid <= 1'b0;
            if ((state == ST_HOLD) && stop_ev) begin
                req_valid <= 1'b1;
                req_op    <= op_q;
                req_pot   <= pot_q;
                req_reg   <= reg_q;
                req_data  <= data_q;
                req_up    <= 1'b0;
            end else if ((state == ST_STEP) && scl_fall && step_arm) begin
                req_valid <= 1'b1;
                req_op    <= op_q;
                req_pot   <= pot_q;
                req_reg   <= reg_q;
                req_data  <= data_q;
                req_up    <= step_dir;
            end
        end
    end

    assign sel_pot   = pot_q;
    assign sel_reg   = reg_q;
    assign sel_wiper = (op_q == OP_RDW);

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> !$past(bank_busy)); // R3

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R6

    AST_CMD_REQ_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != OP_STEP) |-> ($past(state) == ST_HOLD && $past(stop_ev))); // R8

    AST_DRIVE_IN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_INSTR_ACK ||
                    state == ST_WR_ACK || state == ST_RD_DATA)); // R9

    AST_STEP_FROM_STEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_STEP) |-> $past(state) == ST_STEP); // R10

    AST_SDA_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && scl_lvl) |-> !sda_oe); // R11
endmodule

// File: rtl/tw_pot_cmd_frontend.sv
module tw_pot_cmd_frontend
    import tw_pkg::*;
#(
    parameter logic [3:0] TYPE_CODE   = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [3:0]        dev_addr,
    input  logic              bank_busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sel_pot,
    output logic [1:0]        sel_reg,
    output logic              sel_wiper,
    output logic              req_valid,
    output logic [3:0]        req_op,
    output logic              req_pot,
    output logic [1:0]        req_reg,
    output logic [BYTE_W-1:0] req_data,
    output logic              req_up
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0] op_nib;
    cmd_cls_e   cls;

    tw_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    tw_instr_decode u_dec (
        .op_nib(op_nib), .cls(cls)
    );

    tw_cmd_fsm #(.TYPE_CODE(TYPE_CODE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
        .stop_ev(stop_ev), .dev_addr(dev_addr), .bank_busy(bank_busy),
        .rd_data(rd_data), .cls_in(cls), .op_nib(op_nib), .sda_oe(sda_oe),
        .sel_pot(sel_pot), .sel_reg(sel_reg), .sel_wiper(sel_wiper),
        .req_valid(req_valid), .req_op(req_op), .req_pot(req_pot),
        .req_reg(req_reg), .req_data(req_data), .req_up(req_up)
    );
endmodule

// File: tb/test_tw_pot_cmd_frontend.sv
module test_tw_pot_cmd_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [3:0] DEV = 4'h6;
    localparam logic [7:0] ADDR_OK = {4'b0101, DEV};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       bank_busy = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] rd_data;
    logic       sel_pot, sel_wiper, req_valid, req_pot, req_up;
    logic [1:0] sel_reg, req_reg;
    logic [3:0] req_op;
    logic [7:0] req_data;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    int up_cnt = 0;
    logic [3:0] l_op;
    logic       l_pot, l_up;
    logic [1:0] l_reg;
    logic [7:0] l_data;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data = sel_wiper ? {2'b00, (sel_pot ? 6'h15 : 6'h2A)}
                               : {4'hA, 1'b0, sel_pot, sel_reg};

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_pot_cmd_frontend i_tw_pot_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .dev_addr(DEV), .bank_busy(bank_busy),
        .rd_data(rd_data), .sel_pot(sel_pot), .sel_reg(sel_reg),
        .sel_wiper(sel_wiper), .req_valid(req_valid), .req_op(req_op),
        .req_pot(req_pot), .req_reg(req_reg), .req_data(req_data),
        .req_up(req_up)
    );

    always @(negedge clk) begin
        if (req_valid) begin
            req_cnt++;
            if (req_up) up_cnt++;
            l_op = req_op; l_pot = req_pot; l_reg = req_reg;
            l_data = req_data; l_up = req_up;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        #(n * CLK_PERIOD);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q + 10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic steady);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0;
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1;
        wq(1); a1 = ~sda_line;
        wq(Q - 2); a2 = ~sda_line;
        wq(1); scl_m = 1'b0;
        ack = a1 & a2;
        steady = (a1 == a2);
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic released);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq(Q); scl_m = 1'b1; wq(Q/2); b = {b[6:0], sda_line}; wq(Q/2); scl_m = 1'b0;
        end
        wq(Q); sda_m = 1'b1; scl_m = 1'b1; wq(Q/2);
        released = ~sda_oe;
        wq(Q/2); scl_m = 1'b0; wq(Q);
    endtask

    task automatic step_pulse(input logic dir);
        sda_m = dir; wq(Q); scl_m = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 req_valid after reset", req_valid, 0);
    endtask

    task automatic t_address();
        logic ack, st;
        int c0 = req_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st);
        chk("R2 matching address ack", ack, 1);
        chk("R11 ack held across SCL high", st, 1);
        bus_stop();
        bus_start(); send_byte({4'b0101, DEV ^ 4'h1}, ack, st);
        chk("R2 wrong pin address nack", ack, 0);
        send_byte(8'hD6, ack, st);
        chk("R2 byte after mismatch ignored", ack, 0);
        bus_stop();
        bus_start(); send_byte({4'b0110, DEV}, ack, st);
        chk("R2 wrong type code nack", ack, 0);
        bus_stop();
        chk("R2 no request after address traffic", req_cnt - c0, 0);
    endtask

    task automatic t_busy();
        logic ack, st;
        bank_busy = 1'b1;
        bus_start(); send_byte(ADDR_OK, ack, st);
        chk("R3 busy bank address nack", ack, 0);
        bus_stop();
        bank_busy = 1'b0;
        bus_start(); send_byte(ADDR_OK, ack, st);
        chk("R3 idle bank poll ack", ack, 1);
        bus_stop();
    endtask

    task automatic t_two_byte(input logic [7:0] ins);
        logic ack, st;
        int c0 = req_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st); send_byte(ins, ack, st);
        chk("R4 defined opcode ack", ack, 1);
        wq(Q);
        chk("R8 no request before stop", req_cnt - c0, 0);
        bus_stop();
        chk("R6 one request after stop", req_cnt - c0, 1);
        chk("R6 request opcode", l_op, ins[7:4]);
        chk("R6 request pot", l_pot, ins[2]);
        chk("R6 request register", l_reg, ins[1:0]);
    endtask

    task automatic t_write(input logic [7:0] ins, input logic [7:0] d);
        logic ack, st;
        int c0 = req_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st); send_byte(ins, ack, st);
        send_byte(d, ack, st);
        chk("R7 data byte ack", ack, 1);
        wq(Q);
        chk("R8 write waits for stop", req_cnt - c0, 0);
        bus_stop();
        chk("R7 one write request", req_cnt - c0, 1);
        chk("R7 write opcode", l_op, ins[7:4]);
        chk("R7 write data", l_data, d);
    endtask

    task automatic t_abort();
        logic ack, st;
        int c0 = req_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st); send_byte(8'hD6, ack, st);
        bus_start(); send_byte(ADDR_OK, ack, st);
        bus_stop();
        chk("R8 repeated start drops command", req_cnt - c0, 0);
    endtask

    task automatic t_bad(input logic [7:0] ins);
        logic ack, st;
        int c0 = req_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st); send_byte(ins, ack, st);
        chk("R5 undefined opcode nack", ack, 0);
        bus_stop();
        chk("R5 no request for undefined opcode", req_cnt - c0, 0);
    endtask

    task automatic t_read(input logic [7:0] ins, input logic [7:0] exp, input logic wip);
        logic ack, st, rel;
        logic [7:0] got;
        int c0 = req_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st); send_byte(ins, ack, st);
        chk("R9 read opcode ack", ack, 1);
        chk("R9 wiper select flag", sel_wiper, wip);
        recv_byte(got, rel);
        chk("R9 read byte MSB first", got, exp);
        chk("R9 SDA released for master ack", rel, 1);
        bus_stop();
        chk("R9 read issues no request", req_cnt - c0, 0);
    endtask

    task automatic t_step();
        logic ack, st;
        int c0 = req_cnt;
        int u0 = up_cnt;
        bus_start(); send_byte(ADDR_OK, ack, st); send_byte(8'h24, ack, st);
        chk("R10 step opcode ack", ack, 1);
        wq(Q);
        step_pulse(1'b1); step_pulse(1'b1); step_pulse(1'b0);
        wq(4);
        chk("R10 last step direction down", l_up, 0);
        chk("R10 step opcode on request", l_op, 4'b0010);
        chk("R10 step pot", l_pot, 1);
        bus_stop();
        chk("R10 three steps, none at stop", req_cnt - c0, 3);
        chk("R10 two upward steps", up_cnt - u0, 2);
    endtask

    initial begin
        #2;
        wq(5);
        t_reset();
        rst_n = 1'b1;
        wq(5);
        t_address();
        t_busy();
        t_two_byte(8'hD6);
        t_two_byte(8'hE1);
        t_two_byte(8'h13);
        t_two_byte(8'h80);
        t_write(8'hC3, 8'h5C);
        t_write(8'hA4, 8'h21);
        t_abort();
        t_bad(8'h30);
        t_bad(8'hF2);
        t_read(8'hB5, 8'hA5, 1'b0);
        t_read(8'h90, 8'h2A, 1'b1);
        t_step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule